// File: doc/BRIEF.md
# Cascadable Bidirectional LCD Row Scan Driver

This block is the digital core of a row (common) driver for a dot-matrix LCD panel with 64 output channels. A one-bit scan token moves through a 64-stage shift register. The register advances on the falling edge of the shift clock. A direction input chooses which end of the register takes new data and which end drives the cascade output. The two bidirectional end pins are each modelled as three signals: an input, an output and an output enable. Because the cascade output of one device feeds the input pin of the next, devices can be chained to scan 128 rows or more.

Each channel combines its stage bit, the frame alternation signal and an active-low display-off input into a 2-bit drive-level code. Four codes exist: `00` is the high selected level, `01` the upper non-selected level, `10` the lower non-selected level and `11` the low selected level. Analog level shifting and bias generation are outside this block.

Top module: `lcd_common_drv`

## Requirements
- R1: With `rst_n` low at a falling edge of `shift_clk`, every stage clears to 0. With `blank_n` high and `alt_m` low afterwards, every channel code is `01`.
- R2: Stages change only on the falling edge of `shift_clk`. A rising edge leaves every channel code unchanged.
- R3: With `dir_left` at 0, each falling edge loads `end_a_in` into channel 1 (bits [1:0]) and moves every stage one channel toward channel 64. `end_b_out` carries the channel 64 stage, so a token applied before edge 1 appears there after edge 64 and not after edge 63.
- R4: With `dir_left` at 1, each falling edge loads `end_b_in` into channel 64 (bits [127:126]) and moves every stage one channel toward channel 1. `end_a_out` carries the channel 1 stage, and the token appears there after 64 edges.
- R5: `end_a_oe` equals `dir_left` and `end_b_oe` equals its inverse, so exactly one end pin drives. The output of the end that does not drive reads 0. The input of the end that drives has no effect on the stages.
- R6: With `blank_n` high, the code of channel k (bits [2k-1:2k-2]) is chosen from {`alt_m`, stage}: 00 gives `01`, 01 gives `11`, 10 gives `10`, 11 gives `00`.
- R7: With `blank_n` low, every channel code is `00` regardless of stage or `alt_m`. The change follows `blank_n` without waiting for a clock edge.
- R8: When the cascade output of one device feeds `end_a_in` of a second, both shifting right, a token travels 128 positions. It appears at the second device's `end_b_out` after edge 128 and not after edge 127.
- R9: If the direction is reversed partway through a scan, the stored stages are kept and move back. A token at channel 10 reaches `end_a_out` after 9 left-shift edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; stages advance on its falling edge |
| rst_n | input | 1 | Active-low reset, sampled on the falling edge |
| dir_left | input | 1 | 0: shift toward channel 64; 1: shift toward channel 1 |
| alt_m | input | 1 | Frame alternation signal |
| blank_n | input | 1 | Active-low display-off; low forces code `00` |
| end_a_in | input | 1 | Channel-1 end pin, input side |
| end_a_out | output | 1 | Channel-1 end pin, output side |
| end_a_oe | output | 1 | Channel-1 end pin, output enable |
| end_b_in | input | 1 | Channel-64 end pin, input side |
| end_b_out | output | 1 | Channel-64 end pin, output side |
| end_b_oe | output | 1 | Channel-64 end pin, output enable |
| drive_lvl | output | 128 | Packed 2-bit drive code per channel, channel 1 in bits [1:0] |

## Verification
Two things can happen in the same cycle: a shift edge can move a token while blanking or alternation changes the code of that same channel, and a direction reversal can fall on the edge that loads new data. Random stimulus toggles `blank_n`, `alt_m` and `dir_left` together with the data entering at both ends. After every edge, the whole 128-bit code bus and both end pins are compared with a bench model of the stages. Directed windows between edges change `blank_n` and `alt_m` with no clock to show that the level map reacts at once while the stages hold.

// File: rtl/lcdc_pkg.sv
`timescale 1ns/1ps
// Package lcdc_pkg
// Shared drive-level encoding and the per-channel level mapping function.
// Assumes: 2-bit codes are decoded by the analog level shifter downstream.
package lcdc_pkg;

    typedef enum logic [1:0] {
        LVL_SEL_HI   = 2'b00,
        LVL_NSEL_HI  = 2'b01,
        LVL_NSEL_LO  = 2'b10,
        LVL_SEL_LO   = 2'b11
    } drive_lvl_e;

    // Map alternation, stage data and display-off to a drive code.
    function automatic drive_lvl_e pick_level(input logic alt, input logic dat,
                                              input logic blank_n);
        drive_lvl_e lv;
        if (!blank_n) begin
            lv = LVL_SEL_HI;
        end else begin
            unique case ({alt, dat})
                2'b00:   lv = LVL_NSEL_HI;
                2'b01:   lv = LVL_SEL_LO;
                2'b10:   lv = LVL_NSEL_LO;
                default: lv = LVL_SEL_HI;
            endcase
        end
        return lv;
    endfunction

endpackage

// File: rtl/row_token_shifter.sv
`timescale 1ns/1ps
// Module row_token_shifter
// Bidirectional N-stage shift register clocked on the falling clock edge.
// dir_left=0 loads a_in into stage 0 and moves data upward; dir_left=1 loads
// b_in into stage N-1 and moves data downward.
// Assumes: synchronous active-low reset, sampled on the same falling edge.
module row_token_shifter #(
    parameter int N_STAGE = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir_left,
    input  logic               a_in,
    input  logic               b_in,
    output logic [N_STAGE-1:0] stage_q
);

    localparam int LAST = N_STAGE - 1;

    logic [N_STAGE-1:0] stage_d;

    // Per-stage next value: neighbour below, neighbour above, or an end input.
    for (genvar i = 0; i < N_STAGE; i++) begin : g_next
        if (i == 0 && i == LAST) begin : g_single
            always_comb stage_d[i] = dir_left ? b_in : a_in;
        end else if (i == 0) begin : g_low_end
            always_comb stage_d[i] = dir_left ? stage_q[i+1] : a_in;
        end else if (i == LAST) begin : g_high_end
            always_comb stage_d[i] = dir_left ? b_in : stage_q[i-1];
        end else begin : g_middle
            always_comb stage_d[i] = dir_left ? stage_q[i+1] : stage_q[i-1];
        end
    end

    // State register: clear on reset, otherwise advance on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    // Reset clears all stages (R1)
    assert_reset_clear_R1: assert property (@(negedge clk)
        !rst_n |=> stage_q == '0);

    // Right shift loads the channel-1 end input (R3)
    assert_right_load_R3: assert property (@(negedge clk) disable iff (!rst_n)
        !dir_left |=> stage_q[0] == $past(a_in));

    // Left shift loads the channel-64 end input (R4)
    assert_left_load_R4: assert property (@(negedge clk) disable iff (!rst_n)
        dir_left |=> stage_q[LAST] == $past(b_in));

endmodule

// File: rtl/end_pin_steer.sv
`timescale 1ns/1ps
// Module end_pin_steer
// Derives the enables and outputs of the two end pins from the direction.
// The end that receives data is left undriven and its output held at 0.
// Assumes: the pad ring combines out/oe/in into real bidirectional pins.
module end_pin_steer (
    input  logic dir_left,
    input  logic low_stage,
    input  logic high_stage,
    output logic a_out,
    output logic a_oe,
    output logic b_out,
    output logic b_oe
);

    // Channel-1 end drives only when shifting toward channel 1.
    always_comb begin
        a_oe  = dir_left;
        a_out = dir_left & low_stage;
    end

    // Channel-N end drives only when shifting toward channel N.
    always_comb begin
        b_oe  = ~dir_left;
        b_out = ~dir_left & high_stage;
    end

endmodule

// File: rtl/drive_level_array.sv
`timescale 1ns/1ps
// Module drive_level_array
// One combinational level selector per channel, packed 2 bits per channel
// with channel 1 in the lowest bits.
// Assumes: alt_m and blank_n are glitch-free at the pad level.
module drive_level_array
    import lcdc_pkg::*;
#(
    parameter int N_CH = 64
) (
    input  logic              alt_m,
    input  logic              blank_n,
    input  logic [N_CH-1:0]   stage,
    output logic [2*N_CH-1:0] lvl
);

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        // Select the drive code for channel k.
        always_comb lvl[2*k +: 2] = pick_level(alt_m, stage[k], blank_n);
    end

endmodule

// File: rtl/lcd_common_drv.sv
`timescale 1ns/1ps
// Module lcd_common_drv
// Row scan driver core: a bidirectional token shifter, end-pin steering and
// a per-channel four-level drive selector.
// Assumes: shift_clk is the panel shift clock; outputs feed level shifters.
module lcd_common_drv #(
    parameter int N_CH = 64
) (
    input  logic              shift_clk,
    input  logic              rst_n,
    input  logic              dir_left,
    input  logic              alt_m,
    input  logic              blank_n,
    input  logic              end_a_in,
    output logic              end_a_out,
    output logic              end_a_oe,
    input  logic              end_b_in,
    output logic              end_b_out,
    output logic              end_b_oe,
    output logic [2*N_CH-1:0] drive_lvl
);

    localparam int LAST = N_CH - 1;

    logic [N_CH-1:0] stage_q;

    row_token_shifter #(.N_STAGE(N_CH)) u_shift (
        .clk      (shift_clk),
        .rst_n    (rst_n),
        .dir_left (dir_left),
        .a_in     (end_a_in),
        .b_in     (end_b_in),
        .stage_q  (stage_q)
    );

    end_pin_steer u_steer (
        .dir_left   (dir_left),
        .low_stage  (stage_q[0]),
        .high_stage (stage_q[LAST]),
        .a_out      (end_a_out),
        .a_oe       (end_a_oe),
        .b_out      (end_b_out),
        .b_oe       (end_b_oe)
    );

    drive_level_array #(.N_CH(N_CH)) u_lvl (
        .alt_m   (alt_m),
        .blank_n (blank_n),
        .stage   (stage_q),
        .lvl     (drive_lvl)
    );

    // Display-off forces every channel to the high selected level (R7)
    assert_blank_force_R7: assert property (@(negedge shift_clk) disable iff (!rst_n)
        !blank_n |-> drive_lvl == '0);

    // Exactly one end pin drives at any time (R5)
    assert_one_driver_R5: assert property (@(negedge shift_clk) disable iff (!rst_n)
        $countones({end_a_oe, end_b_oe}) == 1);

    // Undriven end reads 0 (R5)
    assert_idle_end_low_R5: assert property (@(negedge shift_clk) disable iff (!rst_n)
        (!end_a_oe |-> !end_a_out) and (!end_b_oe |-> !end_b_out));

endmodule

// File: tb/lcd_common_drv_tb_top.sv
`timescale 1ns/100ps
module lcd_common_drv_tb_top;
    localparam int N = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0, dir_left = 1'b0, a_in = 1'b0, b_in = 1'b0;
    logic alt_m = 1'b0, blank_n = 1'b1;
    logic a_out, a_oe, b_out, b_oe;
    logic [2*N-1:0] lvl;
    logic c_a_out, c_a_oe, c_b_out, c_b_oe;
    logic [2*N-1:0] c_lvl;

    lcd_common_drv #(.N_CH(N)) dut_i (
        .shift_clk(clk), .rst_n(rst_n), .dir_left(dir_left), .alt_m(alt_m),
        .blank_n(blank_n), .end_a_in(a_in), .end_a_out(a_out), .end_a_oe(a_oe),
        .end_b_in(b_in), .end_b_out(b_out), .end_b_oe(b_oe), .drive_lvl(lvl));

    lcd_common_drv #(.N_CH(N)) casc_i (
        .shift_clk(clk), .rst_n(rst_n), .dir_left(1'b0), .alt_m(1'b0),
        .blank_n(1'b1), .end_a_in(b_out), .end_a_out(c_a_out), .end_a_oe(c_a_oe),
        .end_b_in(1'b0), .end_b_out(c_b_out), .end_b_oe(c_b_oe), .drive_lvl(c_lvl));

    int n_chk = 0, n_fail = 0;
    logic model [N];

    function automatic logic [1:0] ref_lvl(logic m, logic d, logic bn);
        if (!bn) return 2'b00;
        case ({m, d})
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b10: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic chk_bit(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic check_state(string req);
        logic [2*N-1:0] e;
        for (int k = 0; k < N; k++) e[2*k +: 2] = ref_lvl(alt_m, model[k], blank_n);
        n_chk++;
        if (lvl !== e) begin
            n_fail++;
            $display("FAIL %s drive_lvl: actual %h expected %h", req, lvl, e);
        end
        chk_bit(req, "end_a_oe", a_oe, dir_left);
        chk_bit(req, "end_b_oe", b_oe, !dir_left);
        chk_bit(req, "end_a_out", a_out, dir_left ? model[0] : 1'b0);
        chk_bit(req, "end_b_out", b_out, dir_left ? 1'b0 : model[N-1]);
    endtask

    // Apply inputs, let one falling edge pass, update the model.
    task automatic apply(logic r, logic d, logic ai, logic bi, logic m, logic bn);
        rst_n = r; dir_left = d; a_in = ai; b_in = bi; alt_m = m; blank_n = bn;
        @(negedge clk);
        #1;
        if (!r) begin
            for (int k = 0; k < N; k++) model[k] = 1'b0;
        end else if (!d) begin
            for (int k = N-1; k > 0; k--) model[k] = model[k-1];
            model[0] = ai;
        end else begin
            for (int k = 0; k < N-1; k++) model[k] = model[k+1];
            model[N-1] = bi;
        end
    endtask

    initial begin
        #(4.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1 reset state
        apply(0, 0, 0, 0, 0, 1);
        apply(0, 0, 0, 0, 0, 1);
        check_state("R1");

        // R2: a rising edge does not shift
        rst_n = 1; a_in = 1;
        @(posedge clk); #0.5;
        check_state("R2");
        apply(1, 0, 1, 0, 0, 1);
        check_state("R2");

        // R3 token right, 64 edges; R5 idle end and ignored input
        apply(0, 0, 0, 0, 0, 1);
        apply(1, 0, 1, 1, 0, 1);
        for (int i = 0; i < 62; i++) apply(1, 0, 0, 1, 0, 1);
        chk_bit("R3", "end_b_out after 63 edges", b_out, 1'b0);
        apply(1, 0, 0, 1, 0, 1);
        chk_bit("R3", "end_b_out after 64 edges", b_out, 1'b1);
        chk_bit("R5", "end_a_out idle", a_out, 1'b0);
        check_state("R3");
        apply(1, 0, 0, 0, 0, 1);
        chk_bit("R3", "end_b_out after 65 edges", b_out, 1'b0);

        // R4 token left; R5 input at driving end ignored
        apply(0, 1, 0, 0, 0, 1);
        apply(1, 1, 1, 1, 0, 1);
        for (int i = 0; i < 62; i++) apply(1, 1, 1, 0, 0, 1);
        chk_bit("R4", "end_a_out after 63 edges", a_out, 1'b0);
        apply(1, 1, 1, 0, 0, 1);
        chk_bit("R4", "end_a_out after 64 edges", a_out, 1'b1);
        chk_bit("R5", "end_b_out idle", b_out, 1'b0);
        check_state("R4");

        // R9 reversal
        apply(0, 0, 0, 0, 0, 1);
        apply(1, 0, 1, 0, 0, 1);
        for (int i = 0; i < 9; i++) apply(1, 0, 0, 0, 0, 1);
        for (int i = 0; i < 8; i++) apply(1, 1, 0, 0, 0, 1);
        chk_bit("R9", "end_a_out after 8 left edges", a_out, 1'b0);
        apply(1, 1, 0, 0, 0, 1);
        chk_bit("R9", "end_a_out after 9 left edges", a_out, 1'b1);
        check_state("R9");

        // R6/R7 full map over a random pattern, changed between edges
        for (int i = 0; i < N; i++) apply(1, 0, 1'($urandom), 0, 0, 1);
        for (int c = 0; c < 4; c++) begin
            alt_m = c[0]; blank_n = c[1];
            #0.5;
            check_state(blank_n ? "R6" : "R7");
        end
        alt_m = 0; blank_n = 1;

        // R8 chained token over 128 positions
        apply(0, 0, 0, 0, 0, 1);
        apply(1, 0, 1, 0, 0, 1);
        for (int i = 0; i < 126; i++) apply(1, 0, 0, 0, 0, 1);
        chk_bit("R8", "chain out after 127 edges", c_b_out, 1'b0);
        apply(1, 0, 0, 0, 0, 1);
        chk_bit("R8", "chain out after 128 edges", c_b_out, 1'b1);

        // Random mix: R6 map with shifts, blanking and reversals together
        for (int i = 0; i < 3000; i++) begin
            logic r, d;
            r = ($urandom % 64) != 0;
            d = (($urandom % 8) == 0) ? !dir_left : dir_left;
            apply(r, d, 1'($urandom), 1'($urandom), 1'($urandom),
                  ($urandom % 8) != 0);
            check_state("R6");
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule